// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte stream into memory buffers that software describes through a ring of two-word receive descriptors. When a frame arrives and reception is on, the engine reads the address word of the current descriptor. If software has handed that descriptor to hardware (bit 0 clear), the frame bytes are written one after another into the buffer that the word points to. The engine then writes the stored length and a truncation flag into the second word and rewrites the address word with bit 0 set, which gives the descriptor back to software.

The first word of a descriptor holds two flags in its low bits: bit 0 says who owns the descriptor, and bit 1 marks the last descriptor of the ring. The buffer address is made of the remaining upper bits. The buffer size comes from a configuration field that counts 64-byte units, so bytes beyond that size are discarded. If the next descriptor is still owned by software, the whole frame is thrown away and a missed-frame counter goes up. The descriptor pointer then stays where it is, so the next frame tries the same slot again.

The memory port is a simple request port. A write request is accepted in the cycle it is raised. A read returns `mem_rdata` together with `mem_rvalid` one or more cycles after the request.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the engine raises no memory request and holds `in_ready` low. It holds `frame_done` low and `missed_count` at zero.
- R2: Each frame starts with a read of the address word at `ring_base` plus eight times the slot index. When bit 0 of that word is clear, frame byte k is written to the byte address formed from bits 31:2 of the word, with bits 1:0 forced to zero, plus k. A byte write uses `mem_be` = one-hot of address bits 1:0, with the byte repeated on all four lanes.
- R3: After the last byte, the word at descriptor address + 4 is written with the stored length in bits 12:0 and the truncation flag in bit 13. All other bits of that word are zero.
- R4: After the length word, the address word is rewritten with bit 0 set and its address and bit 1 unchanged. `frame_done` pulses for one cycle with that write.
- R5: After a stored frame, the next descriptor is the one 8 bytes further on. If the descriptor just used had bit 1 set, the next descriptor is the one at `ring_base`.
- R6: If the fetched address word has bit 0 set, the frame's bytes are accepted and discarded with no memory write. `missed_count` rises by one, and the next frame fetches the same descriptor again.
- R7: The buffer limit is `buf_units` × 64 bytes. Bytes past the limit are not written, the recorded length equals the limit, and bit 13 is set. A frame of exactly the limit is stored whole with bit 13 clear.
- R8: While `rx_enable` is low and no frame is in progress, no descriptor is fetched and `in_ready` stays low. The pending frame waits until reception is enabled.
- R9: With saturation selected, `missed_count` stops at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Reception enable, sampled at frame start |
| ring_base | input | 32 | Byte address of descriptor slot 0 |
| buf_units | input | UNIT_W | Buffer size in 64-byte units |
| in_valid | input | 1 | Frame byte present |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| frame_done | output | 1 | One-cycle pulse as a descriptor is handed back |
| missed_count | output | MISS_W | Frames dropped because the ring was full |

## Verification
The hardest case to reach is the ring wrap that runs straight into a descriptor software has not yet returned. The stimulus stores frames in every slot until it reaches the slot marked last, which also proves that the flag bits are masked out of the buffer address. The next frame then lands on slot 0, which is still marked used. This drop must leave memory untouched and keep the pointer in place. After the testbench returns slot 0, a further frame must land there. A narrow counter instance lets a burst of drops show saturation within a short run.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int WORD_W   = 32;
   localparam int OWN_BIT  = 0;
   localparam int LAST_BIT = 1;
   localparam int DESC_BYTES = 8;
   localparam int UNIT_SHIFT = 6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_STORE,
      ST_DROP,
      ST_WLEN,
      ST_WOWN
   } eng_state_t;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              wrap,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] desc_addr
);
   localparam int STEP_LOG = $clog2(STEP);

   if (STEP < 2 || (1 << STEP_LOG) != STEP) begin : g_bad_step
      $error("rxr_ring_ptr: STEP must be a power of two");
   end

   logic [ADDR_W-1:0] offset;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offset <= '0;
      end else if (advance) begin
         if (wrap) offset <= '0;
         else      offset <= offset + ADDR_W'(STEP);
      end
   end

   assign desc_addr = base + offset;

   AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && wrap) |=> (offset == '0)); // R5
   AST_STEP_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !wrap) |=> (offset == $past(offset) + ADDR_W'(STEP))); // R5
endmodule

// File: rtl/rxr_buf_fill.sv
module rxr_buf_fill #(
   parameter int UNIT_W = 8,
   parameter int SHIFT  = 6,
   parameter int CNT_W  = UNIT_W + SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             byte_fire,
   input  logic [UNIT_W-1:0] units,
   output logic             can_store,
   output logic [CNT_W-1:0] stored_len,
   output logic             truncated
);
   if (CNT_W < UNIT_W + SHIFT) begin : g_bad_cnt
      $error("rxr_buf_fill: counter narrower than the largest buffer");
   end

   logic [CNT_W-1:0] limit;
   assign limit     = CNT_W'({units, {SHIFT{1'b0}}});
   assign can_store = (stored_len < limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored_len <= '0;
         truncated  <= 1'b0;
      end else if (start) begin
         stored_len <= '0;
         truncated  <= 1'b0;
      end else if (byte_fire) begin
         if (can_store) stored_len <= stored_len + 1'b1;
         else           truncated  <= 1'b1;
      end
   end

   AST_TRUNC_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (truncated && $stable(units)) |-> (stored_len == limit)); // R7
endmodule

// File: rtl/rxr_miss_ctr.sv
module rxr_miss_ctr #(
   parameter int MISS_W   = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   output logic [MISS_W-1:0] count
);
   if (MISS_W < 1) begin : g_bad_w
      $error("rxr_miss_ctr: MISS_W must be positive");
   end

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    count <= '0;
         else if (inc && (count != '1)) count <= count + 1'b1;
      end
      AST_MISS_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (count >= $past(count))); // R9
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   count <= '0;
         else if (inc) count <= count + 1'b1;
      end
   end

   AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && (count != '1)) |=> (count == $past(count) + 1'b1)); // R6
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
   parameter int UNIT_W   = 8,
   parameter int LEN_W    = 13,
   parameter int MISS_W   = 16,
   parameter bit MISS_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_enable,
   input  logic [31:0]       ring_base,
   input  logic [UNIT_W-1:0] buf_units,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   output logic              mem_req,
   output logic              mem_we,
   output logic [31:0]       mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              frame_done,
   output logic [MISS_W-1:0] missed_count
);
   import rxr_pkg::*;

   localparam int CNT_W = UNIT_W + UNIT_SHIFT;

   if (UNIT_W < 1 || UNIT_W > 20) begin : g_bad_unit
      $error("rx_ring_engine: UNIT_W out of range");
   end
   if (LEN_W < 8 || LEN_W > WORD_W - 2) begin : g_bad_len
      $error("rx_ring_engine: LEN_W out of range");
   end

   eng_state_t        state, state_nx;
   logic [31:0]       desc_word;
   logic [31:0]       desc_addr;
   logic [31:0]       buf_base;
   logic              byte_fire;
   logic              fill_start;
   logic              can_store;
   logic [CNT_W-1:0]  stored_len;
   logic              truncated;
   logic              miss_inc;
   logic              ptr_advance;
   logic [31:0]       len_word;
   logic [31:0]       byte_addr;

   // ---------------- sub-blocks ----------------
   rxr_ring_ptr #(.ADDR_W(32), .STEP(DESC_BYTES)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (ptr_advance),
      .wrap      (desc_word[LAST_BIT]),
      .base      (ring_base),
      .desc_addr (desc_addr)
   );

   rxr_buf_fill #(.UNIT_W(UNIT_W), .SHIFT(UNIT_SHIFT), .CNT_W(CNT_W)) u_fill (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (fill_start),
      .byte_fire  (byte_fire && (state == ST_STORE)),
      .units      (buf_units),
      .can_store  (can_store),
      .stored_len (stored_len),
      .truncated  (truncated)
   );

   rxr_miss_ctr #(.MISS_W(MISS_W), .SATURATE(MISS_SAT)) u_miss (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (miss_inc),
      .count (missed_count)
   );

   // ---------------- datapath ----------------
   assign in_ready  = (state == ST_STORE) || (state == ST_DROP);
   assign byte_fire = in_valid && in_ready;
   assign buf_base  = {desc_word[31:2], 2'b00};
   assign byte_addr = buf_base + 32'(stored_len);

   always_comb begin
      len_word = '0;
      len_word[LEN_W-1:0] = LEN_W'(stored_len);
      len_word[LEN_W]     = truncated;
   end

   assign fill_start  = (state == ST_FETCH) && mem_rvalid;
   assign miss_inc    = (state == ST_FETCH) && mem_rvalid && mem_rdata[OWN_BIT];
   assign ptr_advance = (state == ST_WOWN);
   assign frame_done  = (state == ST_WOWN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              desc_word <= '0;
      else if ((state == ST_FETCH) && mem_rvalid) desc_word <= mem_rdata;
   end

   // ---------------- control ----------------
   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (rx_enable && in_valid) state_nx = ST_FETCH;
         ST_FETCH: if (mem_rvalid)
                      state_nx = mem_rdata[OWN_BIT] ? ST_DROP : ST_STORE;
         ST_STORE: if (byte_fire && in_last) state_nx = ST_WLEN;
         ST_DROP:  if (byte_fire && in_last) state_nx = ST_IDLE;
         ST_WLEN:  state_nx = ST_WOWN;
         ST_WOWN:  state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = desc_addr;
      mem_be    = 4'h0;
      mem_wdata = '0;
      unique case (state)
         ST_IDLE: begin
            mem_req = rx_enable && in_valid;
         end
         ST_STORE: begin
            mem_req   = byte_fire && can_store;
            mem_we    = 1'b1;
            mem_addr  = byte_addr;
            mem_be    = 4'b0001 << byte_addr[1:0];
            mem_wdata = {4{in_data}};
         end
         ST_WLEN: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = desc_addr + 32'd4;
            mem_be    = 4'hF;
            mem_wdata = len_word;
         end
         ST_WOWN: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_be    = 4'hF;
            mem_wdata = desc_word | (32'd1 << OWN_BIT);
         end
         default: ;
      endcase
   end

   // ---------------- assertions ----------------
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_enable && (state == ST_IDLE)) |-> (!mem_req && !in_ready)); // R8
   AST_NO_WRITE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DROP) |-> !(mem_req && mem_we)); // R6
   AST_DONE_SETS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (mem_req && mem_we && (mem_be == 4'hF) && mem_wdata[OWN_BIT])); // R4
   AST_LEN_BEFORE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> ($past(mem_req) && $past(mem_we) && ($past(mem_addr) == mem_addr + 32'd4))); // R3
   AST_BYTE_LANE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && (state == ST_STORE)) |-> $onehot0(mem_be) && (mem_be != 4'h0)); // R2
endmodule

// File: tb/rx_ring_engine_tb.sv
module rx_ring_engine_tb;
   localparam int MW = 3;
   localparam logic [31:0] RBASE = 32'h100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_enable = 1'b0;
   logic [7:0]  buf_units = 8'd2;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = '0;
   logic        in_last = 1'b0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        frame_done;
   logic [MW-1:0] missed_count;

   int total = 0;
   int bad = 0;
   int n_done = 0;
   int n_wr = 0;
   int n_req = 0;

   logic [31:0] mem [0:1023];

   always #4 clk = ~clk;

   rx_ring_engine #(.UNIT_W(8), .LEN_W(13), .MISS_W(MW), .MISS_SAT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .ring_base(RBASE),
      .buf_units(buf_units), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .frame_done(frame_done),
      .missed_count(missed_count)
   );

   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
         n_req = n_req + 1;
         if (mem_we) begin
            n_wr = n_wr + 1;
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
         end else begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[mem_addr[11:2]];
         end
      end
      if (frame_done) n_done = n_done + 1;
   end

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] rd_byte(input logic [31:0] a);
      return mem[a[11:2]][8*a[1:0] +: 8];
   endfunction

   function automatic logic [31:0] slot_addr(input int i);
      return 32'h400 + 32'(i) * 32'h80;
   endfunction

   task automatic send_frame(input int len, input logic [7:0] seed);
      for (int k = 0; k < len; k++) begin
         in_valid = 1'b1;
         in_data  = seed + 8'(k);
         in_last  = (k == len - 1);
         while (!in_ready) @(negedge clk);
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic check_stored(input string tag, input int slot, input int len,
                               input logic [7:0] seed, input logic [31:0] len_word);
      logic [31:0] ba;
      int errs;
      ba = slot_addr(slot);
      errs = 0;
      for (int k = 0; k < len; k++)
         if (rd_byte(ba + 32'(k)) !== seed + 8'(k)) errs++;
      check({tag, " data"}, 32'(errs), 32'd0);
      check({tag, " length word"}, mem[(RBASE[11:2]) + 10'(2 * slot + 1)], len_word);
   endtask

   // R1
   task automatic t_reset();
      check("R1 in_ready", {31'd0, in_ready}, 32'd0);
      check("R1 mem_req", {31'd0, mem_req}, 32'd0);
      check("R1 frame_done", {31'd0, frame_done}, 32'd0);
      check("R1 missed", 32'(missed_count), 32'd0);
   endtask

   // R2 R3 R4
   task automatic t_basic();
      int d0;
      d0 = n_done;
      send_frame(20, 8'h10);
      check_stored("R2/R3 slot0", 0, 20, 8'h10, 32'd20);
      check("R4 own word slot0", mem[RBASE[11:2]], slot_addr(0) | 32'd1);
      check("R4 done pulse", 32'(n_done - d0), 32'd1);
   endtask

   // R8 R5
   task automatic t_disabled();
      int r0;
      rx_enable = 1'b0;
      in_valid = 1'b1;
      in_data = 8'h00;
      in_last = 1'b0;
      r0 = n_req;
      repeat (10) begin
         @(negedge clk);
         if (in_ready) check("R8 in_ready held low", 32'd1, 32'd0);
      end
      check("R8 no fetch while off", 32'(n_req - r0), 32'd0);
      rx_enable = 1'b1;
      send_frame(9, 8'h40);
      check_stored("R5 next slot1", 1, 9, 8'h40, 32'd9);
   endtask

   // R7
   task automatic t_trunc();
      buf_units = 8'd1;
      send_frame(70, 8'h80);
      check_stored("R7 trunc slot2", 2, 64, 8'h80, 32'd64 | (32'd1 << 13));
      check("R7 byte past limit untouched", {24'd0, rd_byte(slot_addr(2) + 32'd64)}, 32'h0000_00A5);
      send_frame(64, 8'h20);
      check_stored("R7 exact limit slot3", 3, 64, 8'h20, 32'd64);
      buf_units = 8'd2;
   endtask

   // R5 R2 R6
   task automatic t_wrap_and_full();
      int w0;
      send_frame(5, 8'h01);
      send_frame(6, 8'h02);
      send_frame(7, 8'h03);
      send_frame(11, 8'hC0);
      check_stored("R2 masked flags slot7", 7, 11, 8'hC0, 32'd11);
      check("R5 wrap flag kept", mem[RBASE[11:2] + 10'd14], slot_addr(7) | 32'd3);
      w0 = n_wr;
      send_frame(12, 8'h55);
      check("R6 no writes on drop", 32'(n_wr - w0), 32'd0);
      check("R6 missed +1", 32'(missed_count), 32'd1);
      check("R6 slot0 untouched", mem[RBASE[11:2] + 10'd1], 32'd20);
      mem[RBASE[11:2]] = slot_addr(0);
      send_frame(13, 8'h60);
      check_stored("R6 retry lands slot0", 0, 13, 8'h60, 32'd13);
   endtask

   // R9
   task automatic t_saturate();
      mem[RBASE[11:2] + 10'd2] = slot_addr(1) | 32'd1;
      for (int f = 0; f < 9; f++) send_frame(3, 8'(f));
      check("R9 missed saturates", 32'(missed_count), 32'd7);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 32'hA5A5_A5A5;
      for (int i = 0; i < 8; i++) begin
         mem[RBASE[11:2] + 10'(2 * i)]     = slot_addr(i) | ((i == 7) ? 32'd2 : 32'd0);
         mem[RBASE[11:2] + 10'(2 * i + 1)] = 32'd0;
      end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      rx_enable = 1'b1;
      t_basic();
      t_disabled();
      t_trunc();
      t_wrap_and_full();
      t_saturate();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule